// File: doc/BRIEF.md
# Serial-Loaded Clock Freeze Controller

This block lets a system stop or restart individual clock outputs. It takes its setting from a two-wire serial stream made of a free-running serial clock and one data line. A frame is a single low start bit and then twelve data bits. The block collects those bits in a staging register. After the last bit it copies them all at once into the active freeze register.

Each active bit gates one output clock. A 0 parks that output at logic low, and a 1 lets it run. Every gate takes its bit into the output's own clock domain and changes state only while that clock is low. Because of this, no output ever shows a shortened high or low pulse.

Fourteen outputs are handled:

- Twelve outputs are gated. They are group A outputs 0–3, group B outputs 0–3, group C outputs 1–3 and the sync output.
- Two outputs run free at all times: group C output 0 and the feedback clock.

A corrupted serial load therefore cannot stop the feedback loop.

Top module: `clk_freeze_ctl`

## Requirements
- R1: While no frame is in progress, a 1 on the data line at a rising serial-clock edge is ignored. The register value does not change.
- R2: A 0 sampled at a rising serial-clock edge while idle is a start bit. The next 12 rising edges sample data bits 0 to 11, in that order. Bit 0 ends up in `frzReg[0]` and bit 11 in `frzReg[11]`.
- R3: The active register changes only at the rising edge that samples bit 11, and all 12 bits change together. A frame that is only part-way through leaves the register as it was.
- R4: The asynchronous active-low reset sets all 12 freeze bits to 1, so every output runs.
- R5: A freeze bit of 0 holds its output at logic 0. A freeze bit of 1 lets the output follow its source clock.
- R6: Output index map:
  - Indices 0–3 carry group A outputs 0–3, controlled by bits 0–3.
  - Indices 4–7 carry group B outputs 0–3, controlled by bits 4–7.
  - Indices 8–10 carry group C outputs 1–3, controlled by bits 8–10.
  - Index 11 carries the sync output, controlled by bit 11.
- R7: Index 12 (group C output 0) and index 13 (feedback) have no freeze bit and always follow their sources.
- R8: Every high pulse on every output lasts exactly one full high phase of its source clock, including pulses around a freeze or an unfreeze.
- R9: After bit 11 the receiver is idle again. A start bit at the very next rising edge begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| serClk | input | 1 | Free-running serial clock; data is sampled on its rising edge |
| serData | input | 1 | Serial data line; idles high |
| rstN | input | 1 | Asynchronous active-low reset |
| srcClk | input | 14 | Ungated source clocks, one per output (index map in R6, R7) |
| gatedClk | output | 14 | Output clocks after freeze gating |
| frzReg | output | 12 | Active freeze register (1 = run, 0 = frozen) |

## Verification
The bench sends frames in several cases:

- A frame whose bits have no symmetry. A receiver that shifted the wrong way would show a mirrored register and the wrong outputs stopped.
- An all-zero frame. A design that gated the two free outputs would stop the feedback clock.
- A frame paused half-way. A design that applied bits as they arrived would show a mixed register at that point.
- Two frames back to back with no idle gap. A receiver that needed an extra idle cycle would lose the second start bit.

Alongside these, every high pulse on every output is timed. A gate that switched on the enable edge, rather than during the clock's low phase, would produce pulses shorter than a half-period.

// File: rtl/frz_pkg.sv
`timescale 1ns/1ps
package frz_pkg;
  // strobes from the frame sequencer to the register datapath
  typedef struct packed {
    logic shiftEn;  // sample serData into the staging register
    logic commit;   // copy the completed frame into the active register
  } frzStrobe_t;
endpackage

// File: rtl/frz_serial_ctrl.sv
`timescale 1ns/1ps
module frz_serial_ctrl
  import frz_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic       serClk,
  input  logic       rstN,
  input  logic       serData,
  output frzStrobe_t strb,
  output logic       busy
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  typedef enum logic {ST_IDLE, ST_DATA} rxState_t;

  rxState_t        state;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          bitCnt <= '0;
          if (!serData) state <= ST_DATA;   // low level marks a start bit
        end
        ST_DATA: begin
          if (bitCnt == LAST_BIT) begin
            state  <= ST_IDLE;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy         = (state == ST_DATA);
    strb.shiftEn = busy;
    strb.commit  = busy && (bitCnt == LAST_BIT);
  end
endmodule

// File: rtl/frz_serial_data.sv
`timescale 1ns/1ps
module frz_serial_data
  import frz_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              serClk,
  input  logic              rstN,
  input  logic              serData,
  input  frzStrobe_t        strb,
  output logic [DATA_W-1:0] frzReg
);
  logic [DATA_W-1:0] staging;
  logic [DATA_W-1:0] stageNext;

  // first data bit travels down to index 0 after DATA_W shifts
  generate
    if (DATA_W > 1) begin : g_wide
      assign stageNext = {serData, staging[DATA_W-1:1]};
    end else begin : g_narrow
      assign stageNext = serData;
    end
  endgenerate

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      staging <= '1;
      frzReg  <= '1;
    end else begin
      if (strb.shiftEn) staging <= stageNext;
      if (strb.commit)  frzReg  <= stageNext;
    end
  end
endmodule

// File: rtl/frz_clk_gate.sv
`timescale 1ns/1ps
module frz_clk_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic srcClk,
  input  logic rstN,
  input  logic enReq,
  output logic gatedClk
);
  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   enLow;

  // bring the enable into this output's domain
  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) syncPipe <= '1;
    else       syncPipe <= {syncPipe[SYNC_STAGES-2:0], enReq};
  end

  // update only while the clock is low so the AND never truncates a pulse
  always_ff @(negedge srcClk or negedge rstN) begin
    if (!rstN) enLow <= 1'b1;
    else       enLow <= syncPipe[SYNC_STAGES-1];
  end

  assign gatedClk = srcClk & enLow;
endmodule

// File: rtl/clk_freeze_ctl.sv
`timescale 1ns/1ps
module clk_freeze_ctl
  import frz_pkg::*;
#(
  parameter int GATED_N     = 12,
  parameter int FREE_N      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       serClk,
  input  logic                       serData,
  input  logic                       rstN,
  input  logic [GATED_N+FREE_N-1:0]  srcClk,
  output logic [GATED_N+FREE_N-1:0]  gatedClk,
  output logic [GATED_N-1:0]         frzReg
);
  localparam int OUT_N = GATED_N + FREE_N;

  frzStrobe_t strb;
  logic       busy;

  frz_serial_ctrl #(.DATA_W(GATED_N)) u_ctrl (
    .serClk (serClk),
    .rstN   (rstN),
    .serData(serData),
    .strb   (strb),
    .busy   (busy)
  );

  frz_serial_data #(.DATA_W(GATED_N)) u_data (
    .serClk (serClk),
    .rstN   (rstN),
    .serData(serData),
    .strb   (strb),
    .frzReg (frzReg)
  );

  for (genvar g = 0; g < OUT_N; g++) begin : g_out
    if (g < GATED_N) begin : g_gated
      frz_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .srcClk  (srcClk[g]),
        .rstN    (rstN),
        .enReq   (frzReg[g]),
        .gatedClk(gatedClk[g])
      );
    end else begin : g_free
      assign gatedClk[g] = srcClk[g];   // never frozen: keeps the loop alive
    end
  end
endmodule

// File: rtl/frz_checker.sv
`timescale 1ns/1ps
module frz_checker
  import frz_pkg::*;
#(
  parameter int GATED_N = 12,
  parameter int OUT_N   = 14
) (
  input logic               serClk,
  input logic               rstN,
  input logic               serData,
  input logic               busy,
  input frzStrobe_t         strb,
  input logic [GATED_N-1:0] frzReg,
  input logic [OUT_N-1:0]   srcClk,
  input logic [OUT_N-1:0]   gatedClk
);
  // R1: idle line high keeps the receiver idle
  a_r1_idle_high_ignored: assert property (@(posedge serClk) disable iff (!rstN)
    (!busy && serData) |=> !busy);

  // R2: idle low starts a frame
  a_r2_start_detect: assert property (@(posedge serClk) disable iff (!rstN)
    (!busy && !serData) |=> busy);

  // R3: register only moves on the commit edge
  a_r3_hold_between_commits: assert property (@(posedge serClk) disable iff (!rstN)
    !strb.commit |=> $stable(frzReg));

  // R9: receiver idle right after the last bit
  a_r9_idle_after_last: assert property (@(posedge serClk) disable iff (!rstN)
    strb.commit |=> !busy);

  for (genvar g = 0; g < OUT_N; g++) begin : g_chk
    if (g < GATED_N) begin : g_gated
      // R5: a bit held at 0 for several cycles parks the output low
      a_r5_frozen_low: assert property (@(negedge srcClk[g]) disable iff (!rstN)
        (!frzReg[g] && $past(!frzReg[g]) && $past(!frzReg[g], 2) && $past(!frzReg[g], 3))
        |-> !gatedClk[g]);
    end else begin : g_free
      // R7: free outputs are high whenever their source is
      a_r7_free_running: assert property (@(negedge srcClk[g]) disable iff (!rstN)
        gatedClk[g]);
    end
  end
endmodule

bind clk_freeze_ctl frz_checker #(.GATED_N(GATED_N), .OUT_N(OUT_N)) u_chk (
  .serClk  (serClk),
  .rstN    (rstN),
  .serData (serData),
  .busy    (busy),
  .strb    (strb),
  .frzReg  (frzReg),
  .srcClk  (srcClk),
  .gatedClk(gatedClk)
);

// File: tb/sim_clk_freeze_ctl.sv
`timescale 1ns/1ps
module sim_clk_freeze_ctl;
  localparam int GATED_N = 12;
  localparam int OUT_N   = 14;
  localparam real HALF0  = 3.0;   // source i has a half-period of HALF0 + i ns
  localparam int WD_CYC  = 200000;

  logic               serClk = 1'b0;
  logic               serData = 1'b1;
  logic               rstN = 1'b1;
  logic [OUT_N-1:0]   srcClk;
  logic [OUT_N-1:0]   gatedClk;
  logic [GATED_N-1:0] frzReg;

  int nChk = 0;
  int nBad = 0;
  int edgeCnt [OUT_N];
  logic [GATED_N-1:0] expQ [$];
  bit monIdle = 1'b1;

  clk_freeze_ctl u0 (
    .serClk  (serClk),
    .serData (serData),
    .rstN    (rstN),
    .srcClk  (srcClk),
    .gatedClk(gatedClk),
    .frzReg  (frzReg)
  );

  always #4 serClk = ~serClk;   // 125 MHz serial clock

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkPulse(input int idx, input realtime w);
    realtime want;
    realtime diff;
    want = HALF0 + idx;
    diff = (w > want) ? (w - want) : (want - w);
    nChk++;
    if (diff > 0.001) begin
      nBad++;
      $display("FAIL R8 high pulse on output %0d: actual=%0.3f ns expected=%0.3f ns",
               idx, w, want);
    end
  endtask

  for (genvar i = 0; i < OUT_N; i++) begin : g_src
    logic c = 1'b0;
    realtime tRise;
    bit riseOk = 1'b0;
    initial begin
      #(0.37 * i);
      forever #(HALF0 + i) c = ~c;
    end
    assign srcClk[i] = c;
    initial edgeCnt[i] = 0;
    always @(posedge gatedClk[i]) begin
      edgeCnt[i] = edgeCnt[i] + 1;
      if (rstN) begin
        tRise  = $realtime;
        riseOk = 1'b1;
      end
    end
    always @(negedge gatedClk[i]) begin
      if (riseOk) begin
        riseOk = 1'b0;
        checkPulse(i, $realtime - tRise);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic startBit();
    @(negedge serClk) serData = 1'b0;
  endtask

  task automatic shiftOut(input logic [GATED_N-1:0] v, input int from, input int to);
    for (int b = from; b <= to; b++) begin
      @(negedge serClk) serData = v[b];
    end
  endtask

  task automatic idleLine();
    @(negedge serClk) serData = 1'b1;
  endtask

  task automatic waitMonitor();
    wait (expQ.size() == 0);
    wait (monIdle);
  endtask

  task automatic runFrame(input logic [GATED_N-1:0] v);
    startBit();
    shiftOut(v, 0, GATED_N - 1);
    idleLine();
    expQ.push_back(v);
    waitMonitor();
  endtask

  // ---------------- monitor ----------------
  initial begin
    logic [GATED_N-1:0] exp;
    int snap [OUT_N];
    forever begin
      wait (expQ.size() > 0);
      monIdle = 1'b0;
      exp = expQ.pop_front();
      check(frzReg === exp, "R2", "register after frame", 32'(frzReg), 32'(exp));
      #150;
      for (int j = 0; j < OUT_N; j++) snap[j] = edgeCnt[j];
      #300;
      for (int j = 0; j < OUT_N; j++) begin
        bit run;
        bit ok;
        run = (j >= GATED_N) ? 1'b1 : exp[j];
        if (run) ok = (edgeCnt[j] > snap[j]);
        else     ok = (edgeCnt[j] == snap[j]) && (gatedClk[j] === 1'b0);
        if (j >= GATED_N)
          check(ok, "R7", $sformatf("free output %0d edges", j),
                32'(edgeCnt[j] - snap[j]), 32'(1));
        else
          check(ok, run ? "R6" : "R5", $sformatf("output %0d run=%0d edges", j, run),
                32'(edgeCnt[j] - snap[j]), run ? 32'(1) : 32'(0));
      end
      monIdle = 1'b1;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    #(WD_CYC * 8.0);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  // ---------------- sequence ----------------
  initial begin
    #1 rstN = 1'b0;
    #60;
    @(negedge serClk) rstN = 1'b1;
    #1;
    check(frzReg === 12'hFFF, "R4", "register after reset", 32'(frzReg), 32'hFFF);
    expQ.push_back(12'hFFF);   // R4: all outputs run
    waitMonitor();

    // R1: long idle-high stretch changes nothing
    repeat (20) idleLine();
    #1;
    check(frzReg === 12'hFFF, "R1", "register after idle ones", 32'(frzReg), 32'hFFF);

    // R2 R5 R6: asymmetric pattern
    runFrame(12'hA5C);
    // R7: everything frozen except the two free outputs
    runFrame(12'h000);

    // R3: half a frame must not be visible
    startBit();
    shiftOut(12'h3C3, 0, 5);
    #1;
    check(frzReg === 12'h000, "R3", "register mid-frame", 32'(frzReg), 32'h000);
    shiftOut(12'h3C3, 6, GATED_N - 1);
    idleLine();
    expQ.push_back(12'h3C3);
    waitMonitor();

    // R9: second frame starts right after the first with no idle gap
    startBit();
    shiftOut(12'hFFF, 0, GATED_N - 1);
    startBit();
    #1;
    check(frzReg === 12'hFFF, "R9", "first of back-to-back frames", 32'(frzReg), 32'hFFF);
    shiftOut(12'h801, 0, GATED_N - 1);
    idleLine();
    expQ.push_back(12'h801);
    waitMonitor();

    // R8: unfreeze everything once more while pulse timing is watched
    runFrame(12'h7FE);

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule